// File: doc/BRIEF.md
# Scroll Position and Video Memory Address Registers

This block holds the video memory address state of a tile-based picture generator: a 15-bit current address that the fetch logic uses, a 15-bit staging address that the processor fills in pieces, a 3-bit fine horizontal offset, and a single toggle. The toggle is shared by the scroll-register and address-register byte pairs and selects which half a byte write lands in. A processor write port, a data-port access strobe and a status-read strobe make up the processor side. The rendering side has four timing strobes, which come from an external dot and scanline counter: step the coarse column, step the row, copy the horizontal part of the staging address, and copy the vertical part.

Address bit layout, which both sides depend on: bits 4:0 are the coarse column, bits 9:5 the coarse row, bit 10 the horizontal table select, bit 11 the vertical table select, and bits 14:12 the fine row. The current address and the fine horizontal offset are registered outputs.

Top module: `scroll_addr_regs`

## Requirements
- R1: While `rst` is high at a rising clock edge, the current address, staging address, fine X, toggle and step-size flag all become zero.
- R2: A write with `cpu_sel`=0 (control) puts `cpu_wdata`[1:0] into staging bits 11:10 and stores `cpu_wdata`[2] as the step-size flag. It does not change the toggle.
- R3: A write with `cpu_sel`=1 (scroll) and the toggle clear sets fine X to data[2:0] and staging bits 4:0 to data[7:3], then sets the toggle. With the toggle set, it puts data[2:0] into staging bits 14:12 and data[7:3] into staging bits 9:5, then clears the toggle.
- R4: A write with `cpu_sel`=2 (address) and the toggle clear puts data[5:0] into staging bits 13:8, clears staging bit 14 and sets the toggle. With the toggle set, it puts data into staging bits 7:0, loads the whole staging address into the current address on the same edge, and clears the toggle. A write with `cpu_sel`=3 changes nothing.
- R5: A status read clears the toggle. If a write arrives in the same cycle, the write uses the old toggle and the toggle still ends cleared.
- R6: A data-port access adds 32 to the current address when the step-size flag is 1 and 1 when it is 0, wrapping modulo 2^15.
- R7: A coarse-X step turns a coarse column of 31 into 0 and inverts bit 10. Any other column value increments by one.
- R8: A row step increments the fine row when it is below 7. At 7, the fine row becomes 0 and the coarse row advances: 29 becomes 0 and inverts bit 11, 31 becomes 0 without inverting it, and any other value increments.
- R9: A horizontal copy loads the staging bits under mask 0x041F into the current address. A vertical copy loads the bits under mask 0x7BE0. All other bits are kept.
- R10: In a cycle with any processor write or data-port access, the rendering strobes have no effect. A completing address write takes precedence over a data-port access in the same cycle.
- R11: Rendering strobes that arrive together are applied in this order: coarse-X step, row step, horizontal copy, vertical copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Processor register write strobe |
| cpu_sel | input | 2 | Register select: 0 control, 1 scroll, 2 address, 3 none |
| cpu_wdata | input | 8 | Write data |
| data_access | input | 1 | Data-port read or write strobe |
| status_rd | input | 1 | Status register read strobe |
| inc_coarse_x | input | 1 | Coarse column step strobe |
| inc_y | input | 1 | Row step strobe |
| copy_horiz | input | 1 | Horizontal copy strobe |
| copy_vert | input | 1 | Vertical copy strobe |
| cur_addr | output | 15 | Current video memory address |
| fine_x | output | 3 | Fine horizontal pixel offset |

## Verification
Every input takes effect on the rising edge where it is sampled, and both outputs are registers. A change made by a strobe therefore shows on `cur_addr` and `fine_x` one edge after the strobe is presented. The bench drives each strobe on a falling edge, and a behavioural model advances on the next rising edge. The outputs are compared with the model on the falling edge that follows, half a period after they settle. Staging-address contents have no output of their own, so they are observed through the copy strobes and the completing address write, each one edge later.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  parameter int ADDR_W   = 15;
  parameter int DATA_W   = 8;
  parameter int FINE_W   = 3;
  parameter int COARSE_W = 5;
  parameter int SEL_W    = 2;

  localparam int CX_LO  = 0;
  localparam int CY_LO  = CX_LO + COARSE_W;
  localparam int NTX    = CY_LO + COARSE_W;
  localparam int NTY    = NTX + 1;
  localparam int FY_LO  = NTY + 1;
  localparam int CX_HI  = CY_LO - 1;
  localparam int CY_HI  = NTX - 1;
  localparam int FY_HI  = FY_LO + FINE_W - 1;

  localparam logic [COARSE_W-1:0] CX_LAST  = '1;
  localparam logic [COARSE_W-1:0] CY_VIS   = 5'd29;
  localparam logic [COARSE_W-1:0] CY_LAST  = '1;
  localparam logic [FINE_W-1:0]   FY_LAST  = '1;
  localparam logic [ADDR_W-1:0]   H_MASK   = 15'h041F;
  localparam logic [ADDR_W-1:0]   V_MASK   = 15'h7BE0;
  localparam logic [ADDR_W-1:0]   STEP_ROW = ADDR_W'(1) << COARSE_W;
  localparam logic [ADDR_W-1:0]   STEP_ONE = ADDR_W'(1);

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_SCROLL = 2'd1,
    SEL_ADDR   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scroll_cpu_port.sv
module scroll_cpu_port
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              status_rd,
  output logic [ADDR_W-1:0] temp_q,
  output logic [FINE_W-1:0] fine_x_q,
  output logic              toggle_q,
  output logic              stride_q,
  output logic              load_cur,
  output logic [ADDR_W-1:0] load_val
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  assign load_cur = wr_en && (sel == SEL_ADDR) && toggle_q;
  assign load_val = {temp_q[ADDR_W-1:DATA_W], wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q   <= '0;
      fine_x_q <= '0;
      toggle_q <= 1'b0;
      stride_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_CTRL: begin
            temp_q[NTY:NTX] <= wr_data[1:0];
            stride_q        <= wr_data[2];
          end
          SEL_SCROLL: begin
            if (!toggle_q) begin
              fine_x_q           <= wr_data[FINE_W-1:0];
              temp_q[CX_HI:CX_LO] <= wr_data[DATA_W-1:FINE_W];
              toggle_q           <= 1'b1;
            end else begin
              temp_q[FY_HI:FY_LO] <= wr_data[FINE_W-1:0];
              temp_q[CY_HI:CY_LO] <= wr_data[DATA_W-1:FINE_W];
              toggle_q            <= 1'b0;
            end
          end
          SEL_ADDR: begin
            if (!toggle_q) begin
              temp_q[ADDR_W-1:DATA_W] <= {1'b0, wr_data[ADDR_W-DATA_W-2:0]};
              toggle_q                <= 1'b1;
            end else begin
              temp_q[DATA_W-1:0] <= wr_data;
              toggle_q           <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (status_rd) toggle_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scroll_render_step.sv
module scroll_render_step
  import scroll_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] temp_i,
  input  logic              inc_x_i,
  input  logic              inc_y_i,
  input  logic              copy_h_i,
  input  logic              copy_v_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] a;

  always_comb begin
    a = cur_i;
    if (inc_x_i) begin
      if (a[CX_HI:CX_LO] == CX_LAST) begin
        a[CX_HI:CX_LO] = '0;
        a[NTX]         = ~a[NTX];
      end else begin
        a[CX_HI:CX_LO] = a[CX_HI:CX_LO] + 1'b1;
      end
    end
    if (inc_y_i) begin
      if (a[FY_HI:FY_LO] != FY_LAST) begin
        a[FY_HI:FY_LO] = a[FY_HI:FY_LO] + 1'b1;
      end else begin
        a[FY_HI:FY_LO] = '0;
        if (a[CY_HI:CY_LO] == CY_VIS) begin
          a[CY_HI:CY_LO] = '0;
          a[NTY]         = ~a[NTY];
        end else if (a[CY_HI:CY_LO] == CY_LAST) begin
          a[CY_HI:CY_LO] = '0;
        end else begin
          a[CY_HI:CY_LO] = a[CY_HI:CY_LO] + 1'b1;
        end
      end
    end
    if (copy_h_i) a = (a & ~H_MASK) | (temp_i & H_MASK);
    if (copy_v_i) a = (a & ~V_MASK) | (temp_i & V_MASK);
    next_o = a;
  end
endmodule

// File: rtl/scroll_addr_regs.sv
module scroll_addr_regs
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [SEL_W-1:0]  cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              data_access,
  input  logic              status_rd,
  input  logic              inc_coarse_x,
  input  logic              inc_y,
  input  logic              copy_horiz,
  input  logic              copy_vert,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [FINE_W-1:0] fine_x
);
  logic [ADDR_W-1:0] temp_q;
  logic              toggle_q;
  logic              stride_q;
  logic              load_cur;
  logic [ADDR_W-1:0] load_val;
  logic [ADDR_W-1:0] render_next;
  logic [ADDR_W-1:0] step;

  scroll_cpu_port u_port (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cpu_wr),
    .wr_sel    (cpu_sel),
    .wr_data   (cpu_wdata),
    .status_rd (status_rd),
    .temp_q    (temp_q),
    .fine_x_q  (fine_x),
    .toggle_q  (toggle_q),
    .stride_q  (stride_q),
    .load_cur  (load_cur),
    .load_val  (load_val)
  );

  scroll_render_step u_step (
    .cur_i    (cur_addr),
    .temp_i   (temp_q),
    .inc_x_i  (inc_coarse_x),
    .inc_y_i  (inc_y),
    .copy_h_i (copy_horiz),
    .copy_v_i (copy_vert),
    .next_o   (render_next)
  );

  assign step = stride_q ? STEP_ROW : STEP_ONE;

  always_ff @(posedge clk) begin
    if (rst)              cur_addr <= '0;
    else if (load_cur)    cur_addr <= load_val;
    else if (data_access) cur_addr <= cur_addr + step;
    else if (!cpu_wr)     cur_addr <= render_next;
  end
endmodule

// File: rtl/scroll_addr_regs_chk.sv
module scroll_addr_regs_chk
  import scroll_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic [SEL_W-1:0]  cpu_sel,
  input logic              data_access,
  input logic              status_rd,
  input logic              inc_coarse_x,
  input logic              inc_y,
  input logic              copy_horiz,
  input logic              copy_vert,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [FINE_W-1:0] fine_x,
  input logic [ADDR_W-1:0] temp_q,
  input logic              toggle_q,
  input logic              stride_q
);
  logic any_pulse;
  assign any_pulse = inc_coarse_x | inc_y | copy_horiz | copy_vert;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && fine_x == '0 && temp_q == '0 && !toggle_q)); // R1

  AST_STATUS_CLEARS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> !toggle_q); // R5

  AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_access && !cpu_wr) |=>
      cur_addr == $past(cur_addr) + ($past(stride_q) ? 15'd32 : 15'd1)); // R6

  AST_COARSE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc_coarse_x && !inc_y && !copy_horiz && !copy_vert && !cpu_wr && !data_access
     && cur_addr[CX_HI:CX_LO] == CX_LAST) |=>
      (cur_addr[CX_HI:CX_LO] == '0 && cur_addr[NTX] != $past(cur_addr[NTX]))); // R7

  AST_HORIZ_COPY: assert property (@(posedge clk) disable iff (rst)
    (copy_horiz && !copy_vert && !cpu_wr && !data_access) |=>
      ((cur_addr & H_MASK) == ($past(temp_q) & H_MASK))); // R9

  AST_VERT_COPY: assert property (@(posedge clk) disable iff (rst)
    (copy_vert && !cpu_wr && !data_access) |=>
      ((cur_addr & V_MASK) == ($past(temp_q) & V_MASK))); // R9

  AST_CPU_BLOCKS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (any_pulse && cpu_wr && cpu_sel != SEL_ADDR && !data_access) |=>
      $stable(cur_addr)); // R10
endmodule

bind scroll_addr_regs scroll_addr_regs_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr       (cpu_wr),
  .cpu_sel      (cpu_sel),
  .data_access  (data_access),
  .status_rd    (status_rd),
  .inc_coarse_x (inc_coarse_x),
  .inc_y        (inc_y),
  .copy_horiz   (copy_horiz),
  .copy_vert    (copy_vert),
  .cur_addr     (cur_addr),
  .fine_x       (fine_x),
  .temp_q       (temp_q),
  .toggle_q     (toggle_q),
  .stride_q     (stride_q)
);

// File: tb/tb_scroll_addr_regs.sv
module tb_scroll_addr_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_sel = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic       data_access = 1'b0;
  logic       status_rd = 1'b0;
  logic [3:0] pul = 4'd0;
  logic [14:0] cur_addr;
  logic [2:0]  fine_x;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string tag = "R1";

  int m_cur, m_temp, m_fx, m_tog, m_stride;

  always #10 clk = ~clk;

  scroll_addr_regs dut (
    .clk (clk), .rst (rst), .cpu_wr (cpu_wr), .cpu_sel (cpu_sel),
    .cpu_wdata (cpu_wdata), .data_access (data_access), .status_rd (status_rd),
    .inc_coarse_x (pul[0]), .inc_y (pul[1]), .copy_horiz (pul[2]),
    .copy_vert (pul[3]), .cur_addr (cur_addr), .fine_x (fine_x)
  );

  function automatic int rstep(int c, int t, logic [3:0] p);
    int cy;
    if (p[0]) begin
      if ((c & 31) == 31) c = (c & ~31) ^ 'h400;
      else c = c + 1;
    end
    if (p[1]) begin
      if (((c >> 12) & 7) < 7) c = c + 'h1000;
      else begin
        c = c & ~'h7000;
        cy = (c >> 5) & 31;
        if (cy == 29) begin cy = 0; c = c ^ 'h800; end
        else if (cy == 31) cy = 0;
        else cy = cy + 1;
        c = (c & ~'h3E0) | (cy << 5);
      end
    end
    if (p[2]) c = (c & ~'h041F) | (t & 'h041F);
    if (p[3]) c = (c & ~'h7BE0) | (t & 'h7BE0);
    return c & 'h7FFF;
  endfunction

  always @(posedge clk) begin : model
    int nc, nt, nfx, ntg, nst;
    if (rst) begin
      m_cur = 0; m_temp = 0; m_fx = 0; m_tog = 0; m_stride = 0;
    end else begin
      nc = m_cur; nt = m_temp; nfx = m_fx; ntg = m_tog; nst = m_stride;
      if (cpu_wr && cpu_sel == 2 && m_tog == 1) nc = (m_temp & 'h7F00) | cpu_wdata;
      else if (data_access) nc = (m_cur + (m_stride ? 32 : 1)) & 'h7FFF;
      else if (!cpu_wr) nc = rstep(m_cur, m_temp, pul);
      if (cpu_wr) begin
        if (cpu_sel == 0) begin
          nt = (nt & ~'hC00) | ((cpu_wdata & 3) << 10);
          nst = (cpu_wdata >> 2) & 1;
        end else if (cpu_sel == 1) begin
          if (m_tog == 0) begin
            nfx = cpu_wdata & 7;
            nt = (nt & ~'h1F) | (cpu_wdata >> 3);
            ntg = 1;
          end else begin
            nt = (nt & ~'h73E0) | ((cpu_wdata & 7) << 12) | ((cpu_wdata >> 3) << 5);
            ntg = 0;
          end
        end else if (cpu_sel == 2) begin
          if (m_tog == 0) begin
            nt = (nt & 'hFF) | ((cpu_wdata & 'h3F) << 8);
            ntg = 1;
          end else begin
            nt = (nt & 'h7F00) | cpu_wdata;
            ntg = 0;
          end
        end
      end
      if (status_rd) ntg = 0;
      m_cur = nc; m_temp = nt; m_fx = nfx; m_tog = ntg; m_stride = nst;
    end
  end

  always @(negedge clk) begin
    cycles++;
    n_checks++;
    if (cur_addr !== m_cur[14:0] || fine_x !== m_fx[2:0]) begin
      n_fail++;
      $display("FAIL %s: cur_addr=%h fine_x=%0d expected cur_addr=%h fine_x=%0d",
               tag, cur_addr, fine_x, m_cur[14:0], m_fx[2:0]);
    end
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic drive(input logic w, input logic [1:0] s, input logic [7:0] d,
                       input logic a, input logic st, input logic [3:0] p);
    @(negedge clk);
    cpu_wr = w; cpu_sel = s; cpu_wdata = d; data_access = a; status_rd = st; pul = p;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    drive(1, s, d, 0, 0, 0);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1"; idle(); idle();
    tag = "R2"; wr(0, 8'h07); drive(0, 0, 0, 0, 0, 4'b0100); idle();
    tag = "R3"; wr(1, 8'hFD); wr(1, 8'hEE); drive(0, 0, 0, 0, 0, 4'b1100); idle();
    tag = "R4"; wr(2, 8'hFF); wr(2, 8'h5A); idle(); wr(3, 8'hFF); idle();
    tag = "R6"; drive(0, 0, 0, 1, 0, 0); wr(0, 8'h00); drive(0, 0, 0, 1, 0, 0); idle();
    tag = "R5"; wr(2, 8'h21); drive(0, 0, 0, 0, 1, 0); wr(2, 8'h3F); wr(2, 8'h10);
    drive(1, 1, 8'h33, 0, 1, 0); wr(1, 8'h44); idle();
    tag = "R7"; wr(2, 8'h00); wr(2, 8'h1E);
    repeat (3) drive(0, 0, 0, 0, 0, 4'b0001); idle();
    tag = "R8"; wr(2, 8'h73); wr(2, 8'hA0);
    repeat (10) drive(0, 0, 0, 0, 0, 4'b0010);
    wr(2, 8'h73); wr(2, 8'hE0); drive(0, 0, 0, 0, 0, 4'b0010); idle();
    tag = "R9"; wr(0, 8'h02); wr(1, 8'h55); wr(1, 8'h99);
    drive(0, 0, 0, 0, 0, 4'b0100); drive(0, 0, 0, 0, 0, 4'b1000); idle();
    tag = "R10"; drive(1, 1, 8'h12, 0, 0, 4'b1111); drive(0, 0, 0, 1, 0, 4'b1111);
    wr(2, 8'h01); drive(1, 2, 8'h80, 1, 0, 4'b1111); idle();
    tag = "R11"; drive(0, 0, 0, 0, 0, 4'b1111); drive(0, 0, 0, 0, 0, 4'b0011); idle();
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 5) == 0, 2'($urandom), 8'($urandom),
            ($urandom % 8) == 0, ($urandom % 16) == 0,
            (($urandom % 3) == 0) ? 4'($urandom) : 4'd0);
    end
    tag = "R1"; @(negedge clk); rst = 1'b1; idle(); idle(); rst = 1'b0; idle(); idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule